// File: doc/BRIEF.md
# A/D Channel Scan Sequencer

This block decides which analog input an A/D converter samples next and where each finished result is written. A start pulse latches a mode bit and a 3-bit channel code. In single mode the code names one of eight inputs and exactly one conversion is run. In scan mode the top bit of the code picks the lower or upper bank of four inputs. The low two bits give the last input of the run, which always begins at the first input of that bank. The run then repeats until a stop pulse arrives.

Each conversion is a level request held high until the converter answers with a one-cycle done pulse. One cycle after done, the block pulses a write enable and gives the destination index, which is the input's position within its bank. An end flag marks the write that completes a single conversion or a full pass of a scan.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held and right after it, `conv_req_o`, `wr_en_o` and `end_o` are 0.
- R2: In single mode (`scan_mode_i`=0), one conversion is requested with `mux_sel_o` equal to the latched 3-bit code.
- R3: In scan mode with code bit 2 = 0, inputs are converted in ascending order from 0 up to the value of code bits 1:0.
- R4: In scan mode with code bit 2 = 1, inputs are converted in ascending order from 4 up to 4 plus code bits 1:0.
- R5: In scan mode with code bits 1:0 = 00, only the first input of the bank is converted, and every write carries the end flag.
- R6: `wr_en_o` pulses for one cycle, one cycle after the cycle in which `conv_done_i` is high with `conv_req_o`. `wr_idx_o` then equals bits 1:0 of the input just converted.
- R7: A single conversion raises `end_o` with its write, and `conv_req_o` is 0 in that same cycle.
- R8: A scan wraps back to its first input after its last. `end_o` is high only on the write of the last input of each pass.
- R9: `stop_i` without `conv_done_i` during a conversion drops `conv_req_o` in the next cycle, with no write. `stop_i` together with `conv_done_i` still writes that result, then the block goes idle.
- R10: While a conversion or scan runs, `start_i`, `scan_mode_i` and `chan_code_i` have no effect on the inputs selected or the writes.
- R11: While a request waits for done, `mux_sel_o` and `conv_req_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| stop_i | input | 1 | Stop request for a running conversion or scan |
| scan_mode_i | input | 1 | 1 = scan mode, 0 = single mode |
| chan_code_i | input | 3 | Channel code: input number or bank plus last position |
| conv_req_o | output | 1 | Conversion request to the converter |
| conv_done_i | input | 1 | One-cycle conversion-complete pulse |
| mux_sel_o | output | 3 | Analog input currently selected |
| wr_en_o | output | 1 | Result write strobe |
| wr_idx_o | output | 2 | Result register index (position within the bank) |
| end_o | output | 1 | End of single conversion or of a scan pass |

## Verification
A start pulse gives `conv_req_o` and the first `mux_sel_o` one cycle later. A done pulse gives `wr_en_o`, `wr_idx_o` and `end_o` one cycle later, and the next input appears on `mux_sel_o` in that same cycle. A stop without done clears the request one cycle after it is seen. The bench drives every input on the falling edge and samples exactly one falling edge after the rising edge that registers it. A converter model in the bench answers after 2 to 4 cycles. The bench sweeps all sixteen combinations of mode and code. In every run it disturbs the mode, code and start inputs to show that the latched settings govern the selection.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adc_seq_range.sv
// Turns mode and channel code into the first and last input of a run.
module adc_seq_range #(
    parameter int CH_W = 3
) (
    input  logic            scan_mode,
    input  logic [CH_W-1:0] code,
    output logic [CH_W-1:0] first_ch,
    output logic [CH_W-1:0] last_ch
);
    localparam int IDX_W = CH_W - 1;

    always_comb begin
        if (scan_mode) begin
            // bank bit kept, position cleared: run starts at the bank base
            first_ch = {code[CH_W-1], {IDX_W{1'b0}}};
        end else begin
            first_ch = code;
        end
        // in both modes the code itself names the final input of the run
        last_ch = code;
    end
endmodule

// File: rtl/adc_seq_step.sv
// Advances the current input inside [first, last] with wrap-around.
module adc_seq_step #(
    parameter int CH_W = 3
) (
    input  logic [CH_W-1:0] cur_ch,
    input  logic [CH_W-1:0] first_ch,
    input  logic [CH_W-1:0] last_ch,
    output logic [CH_W-1:0] next_ch,
    output logic            at_last
);
    always_comb begin
        at_last = (cur_ch == last_ch);
        next_ch = at_last ? first_ch : cur_ch + 1'b1;
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            scan_mode_i,
    input  logic [CH_W-1:0] chan_code_i,
    output logic            conv_req_o,
    input  logic            conv_done_i,
    output logic [CH_W-1:0] mux_sel_o,
    output logic            wr_en_o,
    output logic [CH_W-2:0] wr_idx_o,
    output logic            end_o
);
    localparam int IDX_W = CH_W - 1;

    typedef struct packed {
        seq_state_e      st;
        logic            single;
        logic [CH_W-1:0] first;
        logic [CH_W-1:0] last;
        logic [CH_W-1:0] cur;
        logic            wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic            eop;
    } seq_t;

    seq_t r_q, r_d;

    logic [CH_W-1:0] rng_first, rng_last;
    logic [CH_W-1:0] nxt_ch;
    logic            at_last;

    adc_seq_range #(.CH_W(CH_W)) u_range (
        .scan_mode (scan_mode_i),
        .code      (chan_code_i),
        .first_ch  (rng_first),
        .last_ch   (rng_last)
    );

    adc_seq_step #(.CH_W(CH_W)) u_step (
        .cur_ch   (r_q.cur),
        .first_ch (r_q.first),
        .last_ch  (r_q.last),
        .next_ch  (nxt_ch),
        .at_last  (at_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.eop   = 1'b0;
        case (r_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    r_d.st     = SEQ_BUSY;
                    r_d.single = !scan_mode_i;
                    r_d.first  = rng_first;
                    r_d.last   = rng_last;
                    r_d.cur    = rng_first;
                end
            end
            SEQ_BUSY: begin
                if (conv_done_i) begin
                    r_d.wr_en  = 1'b1;
                    r_d.wr_idx = r_q.cur[IDX_W-1:0];
                    r_d.eop    = r_q.single || at_last;
                    if (r_q.single || stop_i) begin
                        r_d.st = SEQ_IDLE;
                    end else begin
                        r_d.cur = nxt_ch;
                    end
                end else if (stop_i) begin
                    r_d.st = SEQ_IDLE;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_req_o = (r_q.st == SEQ_BUSY);
    assign mux_sel_o  = r_q.cur;
    assign wr_en_o    = r_q.wr_en;
    assign wr_idx_o   = r_q.wr_idx;
    assign end_o      = r_q.eop;

    // R6: a write follows exactly one accepted done
    assert_write_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(conv_done_i && conv_req_o));

    // R6: index is the bank position of the input that was converted
    assert_index_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o == $past(mux_sel_o[IDX_W-1:0])));

    // R8: end flag only accompanies a write
    assert_end_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> wr_en_o);

    // R7: a finished single conversion leaves the request low
    assert_single_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && r_q.single) |-> !conv_req_o);

    // R11: waiting request keeps its selection
    assert_sel_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_done_i && !stop_i) |=> (conv_req_o && $stable(mux_sel_o)));

    // R3/R4: selection never leaves the latched range
    assert_sel_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> (mux_sel_o >= r_q.first && mux_sel_o <= r_q.last));

    // R9: a stop without done ends the request with no write
    assert_stop_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && stop_i && !conv_done_i) |=> (!conv_req_o && !wr_en_o));
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       scan_mode_i = 1'b0;
    logic [2:0] chan_code_i = 3'd0;
    logic       conv_done_i = 1'b0;
    logic       conv_req_o;
    logic [2:0] mux_sel_o;
    logic       wr_en_o;
    logic [1:0] wr_idx_o;
    logic       end_o;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    adc_scan_seq #(.CH_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .scan_mode_i(scan_mode_i), .chan_code_i(chan_code_i),
        .conv_req_o(conv_req_o), .conv_done_i(conv_done_i),
        .mux_sel_o(mux_sel_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
        .end_o(end_o)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One conversion: called at a falling edge where the request for exp_ch
    // must already be up. The converter model answers after lat cycles.
    task automatic conv_one(input string tag, input int exp_ch, input bit exp_end,
                            input int lat, input bit disturb, input bit stop_now,
                            input bit cur_scan, input logic [2:0] cur_code);
        int bad = 0;
        for (int i = 0; i < lat; i++) begin
            if (!conv_req_o || mux_sel_o != exp_ch[2:0]) bad++;
            if (i > 0 && wr_en_o) bad++;
            if (disturb && i == 0) begin
                // R10: fresh start and new settings while busy
                start_i = 1'b1;
                scan_mode_i = ~cur_scan;
                chan_code_i = ~cur_code;
            end
            if (i == 1) start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        check({tag, "/R11 request+select held"}, bad, 0);
        conv_done_i = 1'b1;
        stop_i = stop_now;
        @(negedge clk);
        conv_done_i = 1'b0;
        stop_i = 1'b0;
        check("R6 write strobe", int'(wr_en_o), 1);
        check("R6 write index", int'(wr_idx_o), exp_ch & 3);
        check({tag, "/R8 end flag"}, int'(end_o), int'(exp_end));
    endtask

    task automatic run_cfg(input bit scan, input logic [2:0] code);
        int first_ch = scan ? (code & 4) : code;
        int last_ch  = code;
        int lat      = 2 + (code % 3);
        string tag   = !scan ? "R2" : ((code & 3) == 0 ? "R5" : (code[2] ? "R4" : "R3"));
        @(negedge clk);
        start_i = 1'b1;
        scan_mode_i = scan;
        chan_code_i = code;
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " request after start"}, int'(conv_req_o), 1);
        if (!scan) begin
            conv_one(tag, code, 1'b1, lat, 1'b1, 1'b0, scan, code);
            check("R7 idle after single", int'(conv_req_o), 0);
        end else begin
            for (int p = 0; p < 2; p++) begin
                for (int ch = first_ch; ch <= last_ch; ch++) begin
                    bit last_of_all = (p == 1) && (ch == last_ch) && !code[0];
                    conv_one(tag, ch, ch == last_ch, lat, ch == first_ch, last_of_all, scan, code);
                end
            end
            if (!code[0]) begin
                check("R9 stop with done -> idle", int'(conv_req_o), 0);
            end else begin
                // R8 wrap: third pass begins at first input, then stop mid-way
                check("R8 wrap to first input", int'(mux_sel_o), first_ch);
                stop_i = 1'b1;
                @(negedge clk);
                stop_i = 1'b0;
                check("R9 stop drops request", int'(conv_req_o), 0);
                check("R9 no write on abort", int'(wr_en_o), 0);
                @(negedge clk);
                check("R9 still no write", int'(wr_en_o), 0);
            end
        end
        scan_mode_i = 1'b0;
        chan_code_i = 3'd0;
        repeat (2) @(negedge clk);
        check("R1/R10 idle between runs", int'(conv_req_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset request", int'(conv_req_o), 0);
        check("R1 reset write", int'(wr_en_o), 0);
        check("R1 reset end", int'(end_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset request", int'(conv_req_o), 0);
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 8; c++) begin
                run_cfg(m[0], c[2:0]);
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule